// File: doc/BRIEF.md
# Transmit Preamble and Burst Limiter

This block frames serial data for a narrowband FM data modulator. A transmit burst opens with a training preamble of fixed length. The preamble is either a simple alternating pattern or a double-bit pattern, chosen at an input. After the preamble the block forwards user bits, one per bit period, paced by an external bit-rate strobe. The line level is positive: a one drives the modulator input high.

The block also limits how long a burst may run. After a fixed number of bit periods of continuous transmission it cuts the burst off and enters a quiet pause of fixed length. A burst request that arrives during the pause waits until the pause has ended. A sticky flag reports any run of identical user bits that is longer than the modulator tolerates. The defaults are sized for 4800 bit/s: a 96-bit (20 ms) preamble, a 24-bit (5 ms) run limit, a 192000-bit (40 s) burst limit and a 9600-bit (2 s) pause.

Top module: `tx_burst_framer`

## Requirements
- R1: After reset, di_out, tx_active, pause_flag, data_ready and run_err are all 0.
- R2: A bit strobe that sees burst_req high while idle starts a burst: tx_active goes to 1 and the first preamble bit is driven in the period that follows.
- R3: With pat_sel = 0, preamble bit k (k counted from 0) is 1 when k is even and 0 when k is odd.
- R4: With pat_sel = 1, preamble bit k is 1 when k mod 4 is 0 or 1, and 0 otherwise.
- R5: The preamble lasts PRE_BITS bit periods. data_ready is 1 only in the last preamble period and in data periods, and only while the burst limit has not been reached.
- R6: A bit presented with data_valid high at a strobe while data_ready is 1 is driven on di_out for the following bit period, with positive polarity.
- R7: A strobe that sees data_valid low while data_ready is 1 ends the burst: di_out and tx_active go to 0 and no pause follows.
- R8: A burst is cut off at the strobe that ends its TX_LIMIT-th bit period. data_ready is 0 in that last period. After the cut-off, pause_flag is 1 and tx_active, di_out and data_ready are 0.
- R9: The pause lasts PAUSE_BITS bit periods, and pause_flag stays 1 for all of them. A burst_req that is held high during the pause starts no burst until the pause has ended.
- R10: run_err becomes 1 once more than MAX_RUN identical consecutive user bits are accepted within a burst, and it stays 1 until reset.
- R11: The outputs change only at clock edges where bit_stb is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_stb | input | 1 | One-cycle strobe marking each bit-period boundary |
| burst_req | input | 1 | Request to start a transmit burst |
| data_valid | input | 1 | User bit is available; low at a ready strobe ends the burst |
| data_bit | input | 1 | User data bit |
| pat_sel | input | 1 | Preamble pattern: 0 alternating, 1 double-bit |
| di_out | output | 1 | Serial line to the modulator input |
| tx_active | output | 1 | Burst in progress (preamble or data) |
| pause_flag | output | 1 | Forced pause in progress |
| data_ready | output | 1 | The next strobe consumes a user bit |
| run_err | output | 1 | Sticky flag for an overlong run of identical bits |

## Verification
The bench builds the block with PRE_BITS = 8, MAX_RUN = 4, TX_LIMIT = 30 and PAUSE_BITS = 5. With these values every preamble bit of both patterns is compared one period at a time, and a whole burst runs into its cut-off in a few dozen strobes. Every period of the pause that follows is also checked, with the request held high. The small run limit puts the boundary between a run of exactly MAX_RUN bits and a run of MAX_RUN + 1 bits inside one short burst.

// File: rtl/tx_burst_framer.sv
module tx_burst_framer #(
  parameter int PRE_BITS   = 96,
  parameter int MAX_RUN    = 24,
  parameter int TX_LIMIT   = 192000,
  parameter int PAUSE_BITS = 9600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_stb,
  input  logic burst_req,
  input  logic data_valid,
  input  logic data_bit,
  input  logic pat_sel,
  output logic di_out,
  output logic tx_active,
  output logic pause_flag,
  output logic data_ready,
  output logic run_err
);
  localparam int PW = (PRE_BITS > 4) ? $clog2(PRE_BITS) : 2;
  localparam int TW = $clog2(TX_LIMIT + 1);
  localparam int QW = (PAUSE_BITS > 2) ? $clog2(PAUSE_BITS) : 1;
  localparam int RW = $clog2(MAX_RUN + 2);
  localparam logic [PW-1:0] PRE_LAST   = PW'(PRE_BITS - 1);
  localparam logic [TW-1:0] TX_LAST    = TW'(TX_LIMIT);
  localparam logic [QW-1:0] PAUSE_LAST = QW'(PAUSE_BITS - 1);
  localparam logic [RW-1:0] RUN_CAP    = RW'(MAX_RUN);

  typedef enum logic [1:0] {S_IDLE, S_PRE, S_DATA, S_PAUSE} st_t;

  st_t           st;
  logic [PW-1:0] idx;
  logic [TW-1:0] tcnt;
  logic [QW-1:0] qcnt;
  logic [RW-1:0] run;
  logic          dbit;

  wire at_limit = (tcnt == TX_LAST);
  wire pre_bit  = pat_sel ? ~idx[1] : ~idx[0];
  wire same     = (st == S_DATA) && (data_bit == dbit);

  assign tx_active  = (st == S_PRE) || (st == S_DATA);
  assign pause_flag = (st == S_PAUSE);
  assign data_ready = !at_limit && ((st == S_DATA) || (st == S_PRE && idx == PRE_LAST));
  assign di_out     = (st == S_PRE) ? pre_bit : (st == S_DATA) ? dbit : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      idx     <= '0;
      tcnt    <= '0;
      qcnt    <= '0;
      run     <= '0;
      dbit    <= 1'b0;
      run_err <= 1'b0;
    end else if (bit_stb) begin
      case (st)
        S_IDLE: if (burst_req) begin
          st   <= S_PRE;
          idx  <= '0;
          tcnt <= TW'(1);
        end
        S_PRE: begin
          if (at_limit) begin
            st   <= S_PAUSE;
            qcnt <= '0;
          end else if (idx == PRE_LAST) begin
            if (data_valid) begin
              st   <= S_DATA;
              dbit <= data_bit;
              run  <= RW'(1);
              tcnt <= tcnt + 1'b1;
            end else begin
              st <= S_IDLE;
            end
          end else begin
            idx  <= idx + 1'b1;
            tcnt <= tcnt + 1'b1;
          end
        end
        S_DATA: begin
          if (at_limit) begin
            st   <= S_PAUSE;
            qcnt <= '0;
          end else if (data_valid) begin
            dbit <= data_bit;
            tcnt <= tcnt + 1'b1;
            if (same) begin
              if (run <= RUN_CAP) run <= run + 1'b1;
              if (run >= RUN_CAP) run_err <= 1'b1;
            end else begin
              run <= RW'(1);
            end
          end else begin
            st <= S_IDLE;
          end
        end
        default: begin
          if (qcnt == PAUSE_LAST) st <= S_IDLE;
          else qcnt <= qcnt + 1'b1;
        end
      endcase
    end
  end

  assert_pause_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pause_flag |-> (!tx_active && !di_out && !data_ready));

  assert_ready_in_burst_R5: assert property (@(posedge clk) disable iff (!rst_n)
    data_ready |-> tx_active);

  assert_line_low_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_active |-> !di_out);

  assert_strobe_paced_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_stb |=> ($stable(tx_active) && $stable(di_out) && $stable(pause_flag)));

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    run_err |=> run_err);

  assert_no_start_in_pause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pause_flag |=> !tx_active);
endmodule

// File: tb/tx_burst_framer_tb.sv
module tx_burst_framer_tb_top;
  localparam int PRE   = 8;
  localparam int RUNL  = 4;
  localparam int LIM   = 30;
  localparam int PAUSE = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_stb = 1'b0, burst_req = 1'b0, data_valid = 1'b0, data_bit = 1'b0, pat_sel = 1'b0;
  logic di_out, tx_active, pause_flag, data_ready, run_err;
  int n_tests = 0, n_fail = 0;

  always #2 clk = ~clk;

  tx_burst_framer #(.PRE_BITS(PRE), .MAX_RUN(RUNL), .TX_LIMIT(LIM), .PAUSE_BITS(PAUSE)) dut_i (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .burst_req(burst_req),
    .data_valid(data_valid), .data_bit(data_bit), .pat_sel(pat_sel),
    .di_out(di_out), .tx_active(tx_active), .pause_flag(pause_flag),
    .data_ready(data_ready), .run_err(run_err));

  task automatic check(input string req, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic strobe();
    @(negedge clk) bit_stb = 1'b1;
    @(negedge clk) bit_stb = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    burst_req = 0; data_valid = 0; data_bit = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  function automatic logic pre_exp(input int p, input int k);
    return p ? logic'((k % 4) < 2) : logic'((k % 2) == 0);
  endfunction

  task automatic start_and_preamble(input int p);
    logic held;
    pat_sel = p[0];
    burst_req = 1'b1; data_valid = 1'b0;
    strobe();
    burst_req = 1'b0;
    check("R2 tx_active at start", tx_active, 1'b1);
    for (int k = 0; k < PRE; k++) begin
      check(p ? "R4 preamble bit" : "R3 preamble bit", di_out, pre_exp(p, k));
      check("R5 data_ready in preamble", data_ready, logic'(k == PRE - 1));
      held = di_out;
      repeat (2) @(negedge clk);
      check("R11 stable between strobes", di_out, held);
      if (k < PRE - 1) strobe();
    end
  endtask

  task automatic send_bit(input logic b);
    check("R5 data_ready before data", data_ready, 1'b1);
    data_bit = b; data_valid = 1'b1;
    strobe();
    check("R6 data on line", di_out, b);
    check("R6 active in data", tx_active, 1'b1);
  endtask

  task automatic end_burst();
    data_valid = 1'b0;
    strobe();
    check("R7 line low at end", di_out, 1'b0);
    check("R7 inactive at end", tx_active, 1'b0);
    check("R7 no pause after end", pause_flag, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    check("R1 di_out", di_out, 1'b0);
    check("R1 tx_active", tx_active, 1'b0);
    check("R1 pause_flag", pause_flag, 1'b0);
    check("R1 data_ready", data_ready, 1'b0);
    check("R1 run_err", run_err, 1'b0);

    for (int p = 0; p < 2; p++) begin
      start_and_preamble(p);
      for (int i = 0; i < 10; i++) send_bit(logic'(((i * 5 + p) % 3) == 0));
      end_burst();
      check("R10 no error for short runs", run_err, 1'b0);
    end

    do_reset();
    start_and_preamble(1);
    send_bit(1'b0);
    for (int i = 0; i < RUNL; i++) send_bit(1'b1);
    check("R10 run of exactly MAX_RUN ones", run_err, 1'b0);
    for (int i = 0; i < RUNL; i++) send_bit(1'b0);
    check("R10 run of exactly MAX_RUN zeros", run_err, 1'b0);
    send_bit(1'b0);
    check("R10 run of MAX_RUN+1 zeros", run_err, 1'b1);
    send_bit(1'b1);
    end_burst();
    check("R10 flag sticky", run_err, 1'b1);

    do_reset();
    start_and_preamble(0);
    for (int t = PRE; t < LIM; t++) send_bit(logic'(t % 2));
    check("R8 data_ready low in last period", data_ready, 1'b0);
    check("R8 still active in last period", tx_active, 1'b1);
    burst_req = 1'b1; data_valid = 1'b1;
    strobe();
    check("R8 pause after limit", pause_flag, 1'b1);
    check("R8 inactive after limit", tx_active, 1'b0);
    check("R8 line low after limit", di_out, 1'b0);
    check("R8 data_ready low after limit", data_ready, 1'b0);
    for (int j = 1; j < PAUSE; j++) begin
      strobe();
      check("R9 pause held", pause_flag, 1'b1);
      check("R9 request held off", tx_active, 1'b0);
    end
    strobe();
    check("R9 pause over", pause_flag, 1'b0);
    check("R9 idle after pause", tx_active, 1'b0);
    strobe();
    check("R9 held request starts burst", tx_active, 1'b1);
    check("R3 first preamble bit after pause", di_out, 1'b1);
    check("R10 no error with alternating data", run_err, 1'b0);
    burst_req = 1'b0;

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule